// File: doc/BRIEF.md
# Time-Scheduled Input Character Source

This block stands in for a slow input device next to a small processor. It holds a short table of scheduled characters, each a release time in clock cycles and an 8-bit value, and a free-running cycle counter. When the counter has reached the release time of the next character and the processor has taken the character before it, the block puts the new value in its input data register and raises the input-ready flag. The processor reads the data register and answers with a one-cycle acknowledge pulse, which drops the flag.

The table and its entry count are loaded through a simple write port before the run. A character whose time passes while the previous one is still unread is held back until the acknowledge arrives. It is never dropped and never written over the unread value. After the last counted entry has been released, the block issues nothing more and shows that it has finished.

Top module: `scripted_input_source`

## Requirements
- R1: After a synchronous reset the ready flag is 0, the data register is 0, the cycle counter is 0, the entry count is 0 and `done` is 1.
- R2: The cycle counter (`cycles`) goes up by one on every clock edge outside reset and wraps modulo 2^TIME_W.
- R3: The next entry is released on the first clock edge at which the counter value before the edge is greater than or equal to the entry's time. With no other hold-up, `ready` and `cycles` are therefore seen as 1 and time+1 after that edge.
- R4: An entry is released only while the ready flag is 0. An entry that falls due while a character is unread is released on the edge after the acknowledge takes effect. It is neither skipped nor reordered.
- R5: On release, the entry's 8-bit value is loaded into `char_out` and `ready` goes to 1 at the same edge.
- R6: An acknowledge pulse while `ready` is 1 clears it at the next edge. No release can take place on that edge, so the earliest next release is one edge later.
- R7: `char_out` does not change while `ready` is 1.
- R8: Entries are released in ascending index order from index 0, one index per release.
- R9: `done` is 1 exactly when the number of released entries is at least the entry count. No release takes place while `done` is 1.
- R10: A table write stores the time and value at the given index. A count write sets how many entries, from index 0 upward, take part in the run (0 to DEPTH).
- R11: An acknowledge while `ready` is 0 has no effect on `ready`, on `char_out` or on the release schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_addr | input | IDX_W | Entry index to write |
| tbl_time | input | TIME_W | Release time of the entry |
| tbl_char | input | CHAR_W | Character value of the entry |
| cnt_we | input | 1 | Entry count write strobe |
| cnt_val | input | IDX_W+1 | Number of entries in the run |
| ack | input | 1 | Processor has taken the character |
| char_out | output | CHAR_W | Input data register |
| ready | output | 1 | Input-ready flag |
| done | output | 1 | All counted entries released |
| cycles | output | TIME_W | Free-running cycle counter |

## Verification
The script mixes four patterns. One entry is already overdue when the count is written, so it shows release on the first possible edge. Another waits for its own time, which separates the time condition from the flag condition. A run of entries with times close together falls due while characters sit unread, which shows deferral instead of loss. An immediate acknowledge that meets an already-due entry shows the one-edge gap after acknowledge. A stray acknowledge while idle and a long wait after the last entry show that idle acknowledges and the end of the table release nothing.

// File: rtl/sis_pkg.sv
package sis_pkg;
  localparam int DEF_DEPTH  = 16;
  localparam int DEF_CHAR_W = 8;
  localparam int DEF_TIME_W = 32;
endpackage

// File: rtl/sis_cycle_counter.sv
module sis_cycle_counter #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [TIME_W-1:0] cyc_o
);
  logic [TIME_W-1:0] cyc_q;

  always_ff @(posedge clk) begin
    if (rst) cyc_q <= '0;
    else     cyc_q <= cyc_q + 1'b1;
  end

  assign cyc_o = cyc_q;

  // R2: one step per edge
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cyc_q == $past(cyc_q) + 1'b1);
endmodule

// File: rtl/sis_entry_table.sv
module sis_entry_table #(
  parameter int DEPTH  = 16,
  parameter int CHAR_W = 8,
  parameter int TIME_W = 32,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int WORD_W = TIME_W + CHAR_W
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [TIME_W-1:0] wtime_i,
  input  logic [CHAR_W-1:0] wchar_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [TIME_W-1:0] rtime_o,
  output logic [CHAR_W-1:0] rchar_o
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= {wtime_i, wchar_i};
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[raddr_i];
  end

  assign rtime_o = rd_q[WORD_W-1:CHAR_W];
  assign rchar_o = rd_q[CHAR_W-1:0];
endmodule

// File: rtl/sis_release_ctrl.sv
module sis_release_ctrl #(
  parameter int DEPTH  = 16,
  parameter int CHAR_W = 8,
  parameter int TIME_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_val_i,
  input  logic              ack_i,
  input  logic [TIME_W-1:0] cyc_i,
  input  logic [TIME_W-1:0] ent_time_i,
  input  logic [CHAR_W-1:0] ent_char_i,
  output logic [IDX_W-1:0]  raddr_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              ready_o,
  output logic              done_o
);
  logic [CNT_W-1:0]  cursor_q, cursor_nxt;
  logic [CNT_W-1:0]  count_q;
  logic [CHAR_W-1:0] char_q;
  logic              ready_q;
  logic              finished;
  logic              due;
  logic              release_now;

  assign finished    = (cursor_q >= count_q);
  assign due         = (cyc_i >= ent_time_i);
  assign release_now = !finished && !ready_q && due;
  assign cursor_nxt  = release_now ? cursor_q + 1'b1 : cursor_q;
  // table read is registered, so look up the entry for the next cursor now
  assign raddr_o     = cursor_nxt[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cursor_q <= '0;
      count_q  <= '0;
      char_q   <= '0;
      ready_q  <= 1'b0;
    end else begin
      cursor_q <= cursor_nxt;
      if (cnt_we_i) count_q <= cnt_val_i;
      if (release_now) begin
        char_q  <= ent_char_i;
        ready_q <= 1'b1;
      end else if (ack_i) begin
        ready_q <= 1'b0;
      end
    end
  end

  assign char_o  = char_q;
  assign ready_o = ready_q;
  assign done_o  = finished;

  // R7: pending character is never replaced
  p_char_held_r7: assert property (@(posedge clk) disable iff (rst)
    (ready_q && !ack_i) |=> $stable(char_q));

  // R6: acknowledge drops the flag on the next edge
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (ready_q && ack_i) |=> !ready_q);

  // R3: a release only happens once its time has come
  p_release_due_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> $past(cyc_i >= ent_time_i));

  // R9: nothing is released after the last counted entry
  p_quiet_when_done_r9: assert property (@(posedge clk) disable iff (rst)
    (finished && !ready_q && !cnt_we_i) |=> !ready_q);

  // R8: cursor moves by at most one per edge
  p_cursor_step_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cursor_q == $past(cursor_q)) || (cursor_q == $past(cursor_q) + 1'b1));
endmodule

// File: rtl/scripted_input_source.sv
module scripted_input_source
  import sis_pkg::*;
#(
  parameter int DEPTH  = DEF_DEPTH,
  parameter int CHAR_W = DEF_CHAR_W,
  parameter int TIME_W = DEF_TIME_W,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [TIME_W-1:0] tbl_time,
  input  logic [CHAR_W-1:0] tbl_char,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              ack,
  output logic [CHAR_W-1:0] char_out,
  output logic              ready,
  output logic              done,
  output logic [TIME_W-1:0] cycles
);
  logic [TIME_W-1:0] cyc;
  logic [TIME_W-1:0] ent_time;
  logic [CHAR_W-1:0] ent_char;
  logic [IDX_W-1:0]  raddr;

  sis_cycle_counter #(.TIME_W(TIME_W)) u_counter (
    .clk   (clk),
    .rst   (rst),
    .cyc_o (cyc)
  );

  sis_entry_table #(.DEPTH(DEPTH), .CHAR_W(CHAR_W), .TIME_W(TIME_W)) u_table (
    .clk     (clk),
    .we_i    (tbl_we),
    .waddr_i (tbl_addr),
    .wtime_i (tbl_time),
    .wchar_i (tbl_char),
    .raddr_i (raddr),
    .rtime_o (ent_time),
    .rchar_o (ent_char)
  );

  sis_release_ctrl #(.DEPTH(DEPTH), .CHAR_W(CHAR_W), .TIME_W(TIME_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cnt_we_i   (cnt_we),
    .cnt_val_i  (cnt_val),
    .ack_i      (ack),
    .cyc_i      (cyc),
    .ent_time_i (ent_time),
    .ent_char_i (ent_char),
    .raddr_o    (raddr),
    .char_o     (char_out),
    .ready_o    (ready),
    .done_o     (done)
  );

  assign cycles = cyc;

  // R11: an idle acknowledge cannot raise or keep the flag by itself
  p_idle_ack_r11: assert property (@(posedge clk) disable iff (rst)
    (!ready && ack) |=> (!ready || $changed(char_out) || char_out == $past(ent_char)));
endmodule

// File: tb/tb_scripted_input_source.sv
module tb_scripted_input_source;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int CHAR_W = 8;
  localparam int TIME_W = 32;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int N_ENT  = 6;

  // script: release time, character, cycles the reader holds it before ack
  localparam logic [31:0] V_TIME [N_ENT] = '{32'd5, 32'd40, 32'd42, 32'd44, 32'd45, 32'd120};
  localparam logic [7:0]  V_CHAR [N_ENT] = '{8'hA5, 8'h3C, 8'h7E, 8'h00, 8'hFF, 8'h5A};
  localparam int          V_HOLD [N_ENT] = '{2, 3, 6, 0, 1, 2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tbl_we = 1'b0;
  logic [IDX_W-1:0]  tbl_addr = '0;
  logic [TIME_W-1:0] tbl_time = '0;
  logic [CHAR_W-1:0] tbl_char = '0;
  logic cnt_we = 1'b0;
  logic [IDX_W:0] cnt_val = '0;
  logic ack = 1'b0;
  logic [CHAR_W-1:0] char_out;
  logic ready, done;
  logic [TIME_W-1:0] cycles;

  int n_checks = 0;
  int n_fail = 0;
  bit finished_run = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scripted_input_source #(.DEPTH(DEPTH), .CHAR_W(CHAR_W), .TIME_W(TIME_W)) dut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_time(tbl_time),
    .tbl_char(tbl_char), .cnt_we(cnt_we), .cnt_val(cnt_val), .ack(ack),
    .char_out(char_out), .ready(ready), .done(done), .cycles(cycles)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    logic [31:0] last_clear;
    logic [31:0] expect_at;
    logic [31:0] prev;
    int wait_n;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cycles == 0, "R1 cycles", cycles, 0);
    check(ready == 1'b0, "R1 ready", {31'd0, ready}, 0);
    check(char_out == 8'h00, "R1 char_out", {24'd0, char_out}, 0);
    check(done == 1'b1, "R1 done with zero count", {31'd0, done}, 1);
    rst = 1'b0;
    @(negedge clk);
    check(cycles == 1, "R2 first step", cycles, 1);
    prev = cycles;
    @(negedge clk);
    check(cycles == prev + 1, "R2 step", cycles, prev + 1);

    // R10: load the script, then the count
    for (int i = 0; i < N_ENT; i++) begin
      tbl_we = 1'b1; tbl_addr = IDX_W'(i); tbl_time = V_TIME[i]; tbl_char = V_CHAR[i];
      @(negedge clk);
    end
    tbl_we = 1'b0;
    check(ready == 1'b0, "R9 no release before count", {31'd0, ready}, 0);
    cnt_we = 1'b1; cnt_val = (IDX_W+1)'(N_ENT);
    @(negedge clk);
    cnt_we = 1'b0;
    last_clear = cycles;
    check(done == 1'b0, "R9 done low after count", {31'd0, done}, 0);

    for (int i = 0; i < N_ENT; i++) begin
      expect_at = (V_TIME[i] + 1 > last_clear + 1) ? V_TIME[i] + 1 : last_clear + 1;
      wait_n = 0;
      while (!ready && wait_n < 400) begin
        @(negedge clk);
        wait_n++;
      end
      // R3/R4: release edge; R5/R8: value and order
      check(cycles == expect_at, $sformatf("R3 R4 release time entry %0d", i), cycles, expect_at);
      check(char_out == V_CHAR[i], $sformatf("R5 R8 value entry %0d", i), {24'd0, char_out}, {24'd0, V_CHAR[i]});
      check(done == (i == N_ENT-1), $sformatf("R9 done entry %0d", i), {31'd0, done}, (i == N_ENT-1));
      for (int h = 0; h < V_HOLD[i]; h++) begin
        @(negedge clk);
        check(ready && char_out == V_CHAR[i], $sformatf("R7 held entry %0d", i), {24'd0, char_out}, {24'd0, V_CHAR[i]});
      end
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      check(ready == 1'b0, $sformatf("R6 ack clears entry %0d", i), {31'd0, ready}, 0);
      last_clear = cycles;
      if (i == 0) begin
        // R11: stray ack while idle, next entry not yet due
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check(ready == 1'b0 && char_out == V_CHAR[0], "R11 idle ack", {24'd0, char_out}, {24'd0, V_CHAR[0]});
      end
    end

    // R9: nothing after the last entry
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (k % 10 == 9)
        check(!ready && done, "R9 quiet after end", {30'd0, ready, done}, 1);
    end
    prev = cycles;
    @(negedge clk);
    check(cycles == prev + 1, "R2 late step", cycles, prev + 1);
    finished_run = 1'b1;
  end

  initial begin
    int t = 0;
    while (!finished_run && t < 100000) begin
      @(posedge clk);
      t++;
    end
    if (!finished_run) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", t);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule